// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block appends event words to a circular queue that lives in memory. Each queue slot is one 32-bit word. The block keeps the position of the next slot to fill and a one-bit generation flag. The generation flag is written into the top bit of every stored word and inverts each time the fill position wraps to slot zero. A consumer that walks the ring can therefore tell a freshly written slot from one left over from the previous lap by comparing that bit with the lap parity it expects. No shared read pointer and no occupancy count are needed.

A producer raises a push with a data word. The block turns it into a single memory write request: the address is the queue base plus four times the fill position. It holds the request until the memory accepts it, then waits for the write response. On a clean response it acknowledges the push and moves the fill position on. On an error response it reports failure and leaves the queue state exactly as it was. A configuration load, accepted only while no push is in flight, sets the base address, the queue size, the fill position, the generation and the sticky wrap status.

Top module: `evq_writer`

## Requirements
- R1: The queue holds 2^(size_code + 10) slots. The fill position always stays below that count, and a loaded position is reduced modulo that count.
- R2: Each memory write request carries the address base + 4 × fill position, truncated to the address width.
- R3: The written word has the current generation bit in bit 31 and bits 30:0 of the pushed data in bits 30:0. Bit 31 of the pushed data is dropped.
- R4: A push is acknowledged with a one-cycle `push_ack` only after an error-free write response. In the cycle after the acknowledge, the fill position equals the old position plus one, modulo the slot count.
- R5: When the advanced fill position is zero, the generation bit inverts and `gen_flipped` takes the new generation value. Otherwise the generation bit and `gen_flipped` are unchanged.
- R6: An error write response produces a one-cycle `push_fail` and no `push_ack`. The fill position, the generation bit and `gen_flipped` are left unchanged.
- R7: Once raised, `mem_valid` stays high with a stable address and data until `mem_ready` is seen high. Exactly one write request is issued per push, and a write response arriving while no write is outstanding is ignored.
- R8: A synchronous active-high reset clears the fill position, the generation bit, `gen_flipped`, the base address and the size code, and drops `mem_valid`.
- R9: `cfg_load` in the idle state loads base, size code, position, generation and `gen_flipped` in one cycle, and it wins over a push in that same cycle. While a push is in flight, `cfg_load` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Load the configuration and queue state below |
| cfg_base | input | ADDR_W | Queue base byte address |
| cfg_size | input | SZ_W | Size code; slot count is 2^(code+10) |
| cfg_index | input | IDX_W | Initial fill position |
| cfg_gen | input | 1 | Initial generation bit |
| cfg_flipped | input | 1 | Initial wrap status |
| push_valid | input | 1 | Push request, held until acknowledged or failed |
| push_data | input | 32 | Event data, bit 31 ignored |
| push_ack | output | 1 | Push stored successfully (one cycle) |
| push_fail | output | 1 | Push dropped after a write error (one cycle) |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_resp_valid | input | 1 | Write response strobe |
| mem_resp_err | input | 1 | Write response reports an error |
| cur_index | output | IDX_W | Current fill position |
| cur_gen | output | 1 | Current generation bit |
| gen_flipped | output | 1 | Sticky copy of the generation at the last wrap |

## Verification
The bench builds the block with a one-bit size code and a 32-bit address. With that setting both legal queue sizes, 1024 and 2048 slots, are small enough to fill slot by slot, so every address, every stored word and both wrap points are checked across two complete laps and the return of the generation to zero. Error responses, a stalled memory, a load whose position is out of range, a load issued in the middle of a push, and a position placed just before the wrap all fit in the same run.

// File: rtl/evq_pkg.sv
package evq_pkg;

    // Smallest queue is 2**BASE_LOG2 slots
    localparam int unsigned BASE_LOG2  = 10;
    // Slots are 4-byte words
    localparam int unsigned SLOT_SHIFT = 2;
    localparam int unsigned WORD_W     = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } evq_state_e;

    typedef struct packed {
        logic valid;
        logic err;
    } evq_resp_t;

    typedef struct packed {
        logic ack;
        logic fail;
    } evq_done_t;

    // Slot mask (count - 1) for a size code, as a 32-bit value
    function automatic logic [31:0] size_mask(input int unsigned code);
        return (32'd1 << (code + BASE_LOG2)) - 32'd1;
    endfunction

    // Stored word: generation on top, data payload below
    function automatic logic [WORD_W-1:0] pack_entry(input logic gen,
                                                     input logic [WORD_W-1:0] d);
        return {gen, d[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/evq_advance.sv
module evq_advance
    import evq_pkg::*;
#(
    parameter int SZ_W  = 2,
    parameter int IDX_W = BASE_LOG2 + (2**SZ_W) - 1
) (
    input  logic [SZ_W-1:0]  size_code,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             gen_in,
    output logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] idx_next,
    output logic             gen_next,
    output logic             wrapped
);
    localparam int NCODES = 2**SZ_W;

    logic [IDX_W-1:0] mask_tab [NCODES];

    for (genvar c = 0; c < NCODES; c++) begin : g_mask
        localparam logic [63:0] M64 = (64'd1 << (c + BASE_LOG2)) - 64'd1;
        assign mask_tab[c] = M64[IDX_W-1:0];
    end

    always_comb begin
        mask     = mask_tab[size_code];
        idx_next = (idx_in + IDX_W'(1)) & mask;
        wrapped  = (idx_next == '0);
        gen_next = gen_in ^ wrapped;
    end

endmodule

// File: rtl/evq_slot_fmt.sv
module evq_slot_fmt
    import evq_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 13
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic              gen,
    input  logic [WORD_W-1:0] data,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);
    localparam int OFS_W = IDX_W + SLOT_SHIFT;

    logic [OFS_W-1:0] byte_ofs;

    always_comb begin
        byte_ofs = {idx, {SLOT_SHIFT{1'b0}}};
        addr     = base + ADDR_W'(byte_ofs);
        word     = pack_entry(gen, data);
    end

endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
    import evq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_ready,
    input  evq_resp_t  resp,
    output logic       idle,
    output logic       issue,
    output evq_done_t  done
);
    evq_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        done.ack  = 1'b0;
        done.fail = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (resp.valid) begin
                    state_d   = ST_IDLE;
                    done.ack  = !resp.err;
                    done.fail = resp.err;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign idle  = (state_q == ST_IDLE);
    assign issue = (state_q == ST_ISSUE);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        issue && !mem_ready |=> issue);

    // R7
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        issue && mem_ready |=> !issue);

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done.ack, done.fail}));

endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int SZ_W   = 2,
    parameter int IDX_W  = BASE_LOG2 + (2**SZ_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [SZ_W-1:0]   cfg_size,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic              cfg_gen,
    input  logic              cfg_flipped,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    output logic              push_ack,
    output logic              push_fail,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_resp_valid,
    input  logic              mem_resp_err,
    output logic [IDX_W-1:0]  cur_index,
    output logic              cur_gen,
    output logic              gen_flipped
);
    logic [ADDR_W-1:0] base_q;
    logic [SZ_W-1:0]   size_q;
    logic [IDX_W-1:0]  idx_q;
    logic              gen_q;
    logic              flip_q;
    logic [WORD_W-1:0] data_q;

    logic              idle, issue, start, load_take;
    evq_resp_t         resp;
    evq_done_t         done;
    logic [IDX_W-1:0]  mask, idx_nx;
    logic              gen_nx, wrapped;
    logic [IDX_W-1:0]  load_idx;

    assign resp.valid = mem_resp_valid;
    assign resp.err   = mem_resp_err;
    assign load_take  = cfg_load && idle;
    assign start      = push_valid && !cfg_load;
    assign load_idx   = cfg_index & size_mask(int'(cfg_size))[IDX_W-1:0];

    evq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ready (mem_ready),
        .resp      (resp),
        .idle      (idle),
        .issue     (issue),
        .done      (done)
    );

    evq_advance #(.SZ_W(SZ_W), .IDX_W(IDX_W)) u_adv (
        .size_code (size_q),
        .idx_in    (idx_q),
        .gen_in    (gen_q),
        .mask      (mask),
        .idx_next  (idx_nx),
        .gen_next  (gen_nx),
        .wrapped   (wrapped)
    );

    evq_slot_fmt #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fmt (
        .base (base_q),
        .idx  (idx_q),
        .gen  (gen_q),
        .data (data_q),
        .addr (mem_addr),
        .word (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            size_q <= '0;
            idx_q  <= '0;
            gen_q  <= 1'b0;
            flip_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (load_take) begin
                base_q <= cfg_base;
                size_q <= cfg_size;
                idx_q  <= load_idx;
                gen_q  <= cfg_gen;
                flip_q <= cfg_flipped;
            end else if (idle && start) begin
                data_q <= push_data;
            end else if (done.ack) begin
                idx_q <= idx_nx;
                if (wrapped) begin
                    gen_q  <= gen_nx;
                    flip_q <= gen_nx;
                end
            end
        end
    end

    assign mem_valid   = issue;
    assign push_ack    = done.ack;
    assign push_fail   = done.fail;
    assign cur_index   = idx_q;
    assign cur_gen     = gen_q;
    assign gen_flipped = flip_q;

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        push_ack |=> cur_index == (($past(cur_index) + IDX_W'(1)) & $past(mask)));

    // R5
    wrap_gen_chk: assert property (@(posedge clk) disable iff (rst)
        push_ack |=> ((cur_index == '0) == (cur_gen != $past(cur_gen))));

    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
        push_ack && !$past(rst) |=> (cur_index == '0) |-> (gen_flipped == cur_gen));

    // R6
    err_keep_chk: assert property (@(posedge clk) disable iff (rst)
        push_fail |=> $stable(cur_index) && $stable(cur_gen) && $stable(gen_flipped));

    // R9
    quiet_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !push_ack && !load_take |=> $stable(cur_index) && $stable(cur_gen)
                                    && $stable(gen_flipped));

    // R7
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> $stable(mem_addr) && $stable(mem_wdata));

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_index & ~mask) == '0);

endmodule

// File: tb/sim_evq_writer.sv
module sim_evq_writer;
    localparam int ADDR_W = 32;
    localparam int SZ_W   = 1;
    localparam int IDX_W  = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [SZ_W-1:0]   cfg_size = '0;
    logic [IDX_W-1:0]  cfg_index = '0;
    logic              cfg_gen = 1'b0;
    logic              cfg_flipped = 1'b0;
    logic              push_valid = 1'b0;
    logic [31:0]       push_data = '0;
    logic              push_ack, push_fail, mem_valid;
    logic              mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_resp_valid = 1'b0;
    logic              mem_resp_err = 1'b0;
    logic [IDX_W-1:0]  cur_index;
    logic              cur_gen, gen_flipped;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state
    logic [ADDR_W-1:0] m_base = '0;
    int unsigned       m_count = 1024;
    int unsigned       m_idx = 0;
    logic              m_gen = 0;
    logic              m_flip = 0;

    always #2 clk = ~clk;

    evq_writer #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .IDX_W(IDX_W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(cur_index == IDX_W'(m_idx), {tag, " index"}, 64'(cur_index), 64'(m_idx));
        chk(cur_gen == m_gen, {tag, " gen"}, 64'(cur_gen), 64'(m_gen));
        chk(gen_flipped == m_flip, {tag, " flipped"}, 64'(gen_flipped), 64'(m_flip));
    endtask

    task automatic load(input logic [ADDR_W-1:0] b, input int unsigned code,
                        input int unsigned idx, input logic g, input logic f);
        @(negedge clk);
        cfg_load = 1; cfg_base = b; cfg_size = SZ_W'(code);
        cfg_index = IDX_W'(idx); cfg_gen = g; cfg_flipped = f;
        push_valid = 1; push_data = 32'h1234_5678; // load must win over push
        @(negedge clk);
        cfg_load = 0; push_valid = 0;
        m_base = b; m_count = 1 << (code + 10);
        m_idx = idx % m_count; m_gen = g; m_flip = f;
    endtask

    // one push; stall = ready-low cycles, err = error response, poke = load during flight
    task automatic push(input logic [31:0] d, input int stall, input bit err,
                        input bit poke, input bit verbose);
        logic [ADDR_W-1:0] ea;
        logic [31:0]       ew;
        @(negedge clk);
        push_valid = 1; push_data = d; mem_ready = 0;
        @(negedge clk);
        ea = m_base + ADDR_W'(m_idx * 4);
        ew = {m_gen, d[30:0]};
        chk(mem_valid == 1, "R7 request raised", 64'(mem_valid), 1);
        chk(mem_addr == ea, "R2 address", 64'(mem_addr), 64'(ea));
        chk(mem_wdata == ew, "R3 word", 64'(mem_wdata), 64'(ew));
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(mem_valid == 1 && mem_addr == ea && mem_wdata == ew,
                "R7 held during stall", 64'(mem_addr), 64'(ea));
        end
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        if (verbose)
            chk(mem_valid == 0, "R7 single request", 64'(mem_valid), 0);
        if (poke) begin
            cfg_load = 1; cfg_index = IDX_W'(5); cfg_gen = ~m_gen; cfg_flipped = ~m_flip;
            @(negedge clk);
            cfg_load = 0;
        end
        mem_resp_valid = 1; mem_resp_err = err;
        #1;
        chk(push_ack == !err, "R4/R6 ack", 64'(push_ack), 64'(!err));
        chk(push_fail == err, "R6 fail", 64'(push_fail), 64'(err));
        push_valid = 0;
        @(negedge clk);
        mem_resp_valid = 0; mem_resp_err = 0;
        if (!err) begin
            m_idx = (m_idx + 1) % m_count;
            if (m_idx == 0) begin m_gen = ~m_gen; m_flip = m_gen; end
        end
        if (verbose || m_idx == 0 || m_idx == 1) chk_state("R4/R5 after push");
        else chk(cur_index == IDX_W'(m_idx), "R1 index", 64'(cur_index), 64'(m_idx));
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h9E37_79B1);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        chk_state("R8 reset");
        chk(mem_valid == 0, "R8 no request", 64'(mem_valid), 0);

        // stray response ignored (R7)
        mem_resp_valid = 1; #1;
        chk(push_ack == 0 && push_fail == 0, "R7 stray response", 64'(push_ack), 0);
        @(negedge clk); mem_resp_valid = 0;
        chk_state("R7 stray response state");

        // R1 R2 R3 R4 R5: two full laps of the 1024-slot queue
        load(32'h8000_1000, 0, 0, 0, 0);
        chk_state("R9 load");
        for (int i = 0; i < 2048; i++) push(pat(i), 0, 0, 0, 0);
        chk_state("R5 after two laps");

        // R6 error leaves state
        push(32'hFFFF_FFFF, 0, 0, 0, 1);
        push(32'h0000_0042, 2, 1, 0, 1);
        chk_state("R6 after error");

        // R7 stall
        push(32'h7FFF_0001, 4, 0, 0, 1);

        // R9 load ignored while busy
        push(32'h0BAD_F00D, 0, 0, 1, 1);

        // R1 loaded position reduced modulo slot count
        load(32'h0000_0FF0, 0, 11'h7FF, 1, 0);
        chk_state("R1 load masked");
        push(32'h8000_0003, 0, 0, 0, 1);
        chk_state("R5 wrap gen 1 to 0");

        // R5 size code 1 near wrap, then full lap of 2048 slots
        load(32'h1000_0000, 1, 2046, 1, 1);
        chk_state("R9 load size 1");
        push(32'h1, 0, 0, 0, 1);
        push(32'h2, 1, 0, 0, 1);
        for (int i = 0; i < 2048; i++) push(pat(i + 7), 0, 0, 0, 0);
        chk_state("R1 lap of 2048");

        // R8 reset mid-run
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        m_base = '0; m_count = 1024; m_idx = 0; m_gen = 0; m_flip = 0;
        @(negedge clk);
        chk_state("R8 reset again");
        push(32'h55, 0, 0, 0, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule